// File: doc/BRIEF.md
# Staircase ADC Conversion Sequencer

This block is the digital half of a counter-type analog-to-digital converter. It drives an unsigned code to an external DAC and watches one comparator bit, which is high while the unknown analog input lies above the DAC output. A start pulse resets the code to zero and the block then raises the code by one every clock. On the first clock where the comparator reads low, the block stops, stores the code in a result register and pulses `done`.

The stored code is the first DAC step that rises above the input. It is not the nearest step. Conversion time follows the input level: a full-scale input needs 2^N clock periods. If the comparator is still high when the code reaches all ones, the block stores all ones, sets an overrange flag and finishes. The DAC and comparator must settle within one clock period, because the comparator bit is sampled at the clock edge that ends each code's cycle.

Top module: `stair_adc_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `overrange`, `result` and `dac_code` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. From the next cycle on, `busy` is 1 and `dac_code` is 0.
- R3: While `busy` is high, `cmp_hi` is 1 and `dac_code` is below all ones, `dac_code` rises by exactly one at each clock.
- R4: The first clock edge during `busy` at which `cmp_hi` is 0 ends the conversion. After that edge, `result` equals the `dac_code` seen at that edge, `overrange` is 0, `done` is high for exactly one cycle, and `busy` is low.
- R5: With a comparator that is high for every code less than or equal to an input level v (v below 2^N-1), `result` is v+1. `done` rises v+2 clock edges after the edge that accepted `start`.
- R6: If `cmp_hi` is still 1 while `dac_code` is all ones, the next edge ends the conversion with `result` all ones and `overrange` 1. `done` rises 2^N edges after the accepting edge.
- R7: A `start` pulse while `busy` is high is ignored. The count continues and the result is unchanged by it.
- R8: `result` and `overrange` change only at an edge that raises `done`. Between conversions, and during a conversion, they keep the previous outcome. A normal completion clears an earlier `overrange`.
- R9: If the input moves during a conversion, `result` is the code at the first edge where the comparator reads low, whatever the input was earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only when idle |
| cmp_hi | input | 1 | Comparator: 1 while the analog input is above the DAC output |
| dac_code | output | ADC_BITS | Code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is stored |
| result | output | ADC_BITS | Last converted code |
| overrange | output | 1 | Last conversion ran past all ones with the comparator high |

## Verification
The bench sweeps every input level, so an off-by-one design shows up as a wrong code or wrong latency at once. Such a design might report the last code below the input, or capture the code one step late. It separates level 2^N-2, which finishes normally at all ones, from level 2^N-1, which must flag overrange. A design that tested only the all-ones code would confuse the two. It sends a restart pulse in the middle of a conversion, which a careless design would use to reset the count. It moves the input during a conversion to show that the captured code tracks the comparator at the moment it switches. It also checks that a stale overrange flag is cleared by the next good conversion.

// File: rtl/stair_adc_pkg.sv
package stair_adc_pkg;

    localparam int DEFAULT_BITS = 8;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Per-cycle commands from the sequencer to the datapath
    typedef struct packed {
        logic clear;    // load zero into the code counter
        logic step;     // advance the code counter by one
        logic capture;  // store the current code as the result
        logic ovr;      // the stored result is an overrange outcome
    } seq_ctl_t;

endpackage

// File: rtl/stair_adc_counter.sv
module stair_adc_counter
    import stair_adc_pkg::*;
#(
    parameter int WIDTH = DEFAULT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_ctl_t         ctl,
    output logic [WIDTH-1:0] code,
    output logic             at_top
);
    localparam logic [WIDTH-1:0] TOP_CODE = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE_CODE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (ctl.clear) begin
            code <= '0;
        end else if (ctl.step) begin
            code <= code + ONE_CODE;
        end
    end

    assign at_top = (code == TOP_CODE);
endmodule

// File: rtl/stair_adc_seq.sv
module stair_adc_seq
    import stair_adc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     cmp_hi,
    input  logic     at_top,
    output seq_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    ctl.clear = 1'b1;
                    state_d   = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (!cmp_hi) begin
                    ctl.capture = 1'b1;
                    state_d     = SEQ_IDLE;
                end else if (at_top) begin
                    ctl.capture = 1'b1;
                    ctl.ovr     = 1'b1;
                    state_d     = SEQ_IDLE;
                end else begin
                    ctl.step = 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= ctl.capture;
        end
    end

    assign busy = (state_q == SEQ_RUN);
endmodule

// File: rtl/stair_adc_hold.sv
module stair_adc_hold
    import stair_adc_pkg::*;
#(
    parameter int WIDTH = DEFAULT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_ctl_t         ctl,
    input  logic [WIDTH-1:0] code,
    output logic [WIDTH-1:0] result,
    output logic             overrange
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (ctl.capture) begin
            result    <= code;
            overrange <= ctl.ovr;
        end
    end
endmodule

// File: rtl/stair_adc_ctrl.sv
module stair_adc_ctrl
    import stair_adc_pkg::*;
#(
    parameter int ADC_BITS = DEFAULT_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cmp_hi,
    output logic [ADC_BITS-1:0] dac_code,
    output logic                busy,
    output logic                done,
    output logic [ADC_BITS-1:0] result,
    output logic                overrange
);
    seq_ctl_t ctl;
    logic     at_top;

    stair_adc_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmp_hi (cmp_hi),
        .at_top (at_top),
        .ctl    (ctl),
        .busy   (busy),
        .done   (done)
    );

    stair_adc_counter #(.WIDTH(ADC_BITS)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .code   (dac_code),
        .at_top (at_top)
    );

    stair_adc_hold #(.WIDTH(ADC_BITS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .code      (dac_code),
        .result    (result),
        .overrange (overrange)
    );
endmodule

// File: rtl/stair_adc_chk.sv
module stair_adc_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             cmp_hi,
    input logic [WIDTH-1:0] dac_code,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             overrange
);
    localparam logic [WIDTH-1:0] TOP_CODE = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE_CODE = {{(WIDTH-1){1'b0}}, 1'b1};

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && dac_code == '0));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cmp_hi && dac_code != TOP_CODE) |=> (busy && dac_code == $past(dac_code) + ONE_CODE));

    assert_stop_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmp_hi) |=> (done && !busy && !overrange && result == $past(dac_code)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_overrange_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && cmp_hi && dac_code == TOP_CODE) |=> (done && overrange && result == TOP_CODE && !busy));

    assert_restart_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (dac_code >= $past(dac_code)));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(overrange)));
endmodule

bind stair_adc_ctrl stair_adc_chk #(.WIDTH(ADC_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmp_hi    (cmp_hi),
    .dac_code  (dac_code),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .overrange (overrange)
);

// File: tb/test_stair_adc_ctrl.sv
module test_stair_adc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8;
    localparam int MAX_CODE   = (1 << NB) - 1;
    localparam int NVEC       = 8;
    // input level, expected result, expected overrange
    localparam int VEC_IN [NVEC] = '{0, 1, 2, 100, 127, 128, MAX_CODE-1, MAX_CODE};
    localparam int VEC_RES[NVEC] = '{1, 2, 3, 101, 128, 129, MAX_CODE,   MAX_CODE};
    localparam bit VEC_OVR[NVEC] = '{0, 0, 0, 0,   0,   0,   0,          1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cmp_hi;
    logic [NB-1:0] dac_code;
    logic          busy, done, overrange;
    logic [NB-1:0] result;
    int            vin = 0;
    int            total = 0;
    int            bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural comparator: input sits half a step above level vin
    assign cmp_hi = (vin >= int'(dac_code));

    stair_adc_ctrl #(.ADC_BITS(NB)) i_stair_adc_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .busy(busy), .done(done),
        .result(result), .overrange(overrange)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One conversion: optional input change and optional restart pulse mid-run.
    task automatic convert(input int v, input int chg_at, input int chg_v,
                           input int restart_at, input int exp_res,
                           input bit exp_ovr, input string req);
        int  cycles;
        bit  step_ok;
        int  prev_res;
        prev_res = int'(result);
        vin = v;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        check(busy == 1'b1 && dac_code == '0, "R2", "busy/code after start",
              int'(dac_code), 0);
        check(int'(result) == prev_res, "R8", "result held during run",
              int'(result), prev_res);
        step_ok = 1'b1;
        while (!done && cycles < MAX_CODE + 10) begin
            if (busy && int'(dac_code) != cycles - 1) step_ok = 1'b0;
            if (cycles == chg_at) vin = chg_v;
            start = (cycles == restart_at);
            @(negedge clk);
            start = 1'b0;
            cycles++;
        end
        check(step_ok, "R3", "code steps once per clock", int'(step_ok), 1);
        check(done == 1'b1 && busy == 1'b0, {req, "/R4"}, "done with busy low",
              int'(done), 1);
        check(int'(result) == exp_res, req, "result", int'(result), exp_res);
        check(overrange == exp_ovr, req, "overrange", int'(overrange), int'(exp_ovr));
        check(cycles == exp_res + 2, req, "latency", cycles, exp_res + 2);
        @(negedge clk);
        check(done == 1'b0, "R4", "done lasts one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog expired: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && overrange == 0 && result == '0 && dac_code == '0,
              "R1", "reset state", int'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0, "R1", "idle after reset", int'(busy), 0);

        // Vector table
        for (int i = 0; i < NVEC; i++)
            convert(VEC_IN[i], -1, 0, -1, VEC_RES[i], VEC_OVR[i],
                    VEC_OVR[i] ? "R6" : "R5");

        // R8: overrange outcome holds while idle, then a normal run clears it
        convert(MAX_CODE, -1, 0, -1, MAX_CODE, 1'b1, "R6");
        repeat (20) @(negedge clk);
        check(overrange == 1 && int'(result) == MAX_CODE, "R8", "held while idle",
              int'(result), MAX_CODE);
        convert(9, -1, 0, -1, 10, 1'b0, "R8");

        // R7: restart pulse in mid-conversion ignored
        convert(50, -1, 0, 10, 51, 1'b0, "R7");

        // R9: input falls during conversion, still above current code
        convert(200, 30, 40, -1, 41, 1'b0, "R9");
        // R9: input falls below current code: capture at that code
        convert(200, 61, 10, -1, 60, 1'b0, "R9");

        // R5/R6: full sweep of every input level
        for (int v = 0; v <= MAX_CODE; v++)
            convert(v, -1, 0, -1, (v == MAX_CODE) ? MAX_CODE : v + 1,
                    v == MAX_CODE, (v == MAX_CODE) ? "R6" : "R5");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule